// File: doc/BRIEF.md
# Dual-mode internal data memory

This block is the internal data space of an 8-bit microcontroller core. It holds 256 bytes of general RAM and a separate 128-byte window of special function registers. Each request carries an access mode beside its address. The block resolves that mode into one physical location and then reads or writes it. The upper half of the address range reaches two different stores. A direct access lands in the function-register window. A pointer-style (indirect) access lands in the upper RAM.

The same access path also folds in three address translations. A register-bank access turns a register number and the current bank into a byte address in the lowest 32 bytes. A bit access turns a 7-bit bit address into a byte and a bit lane of the bit-addressable bytes, and applies set, clear or write as a read-modify-write within the request cycle. A push or pop moves an 8-bit stack pointer that spans the whole RAM and always goes through the RAM path.

The core issues at most one request per cycle. Read data comes back on a fixed one-cycle delay, so no handshake is needed.

Top module: `idm_top`

## Requirements
- R1: A read request returns its data on `rdata` with `rdValid` high in the cycle after the request, and `rdValid` is low in every other cycle. Read requests are modes 0–2 with `reqWrite`=0, mode 3 with `bitOp`=0, and mode 5. A read issued in the cycle right after a write to the same location returns the new value.
- R2: Addresses 00h–7Fh reach the same lower RAM bytes under direct (mode 0) and indirect (mode 1) access.
- R3: Under indirect access (mode 1), addresses 80h–FFh reach the upper 128 bytes of RAM.
- R4: Under direct access (mode 0), addresses 80h–FFh reach the function-register window. That window is storage separate from the upper RAM, and after reset every byte in it reads 00h.
- R5: A register access (mode 2) with register number r and bank b reaches RAM byte b*8+r. A bank request (mode 6) loads the bank from `wdata[1:0]`, whatever the value of `reqWrite`. After reset the bank is 0.
- R6: A bit access (mode 3) maps bit address `addr[6:0]` to RAM byte 20h+`addr[6:3]`, lane `addr[2:0]`; `addr[7]` is ignored. A bit read (`bitOp`=0) returns the bit in `rdata[0]` with all other bits 0.
- R7: The bit operations set (`bitOp`=1), clear (`bitOp`=2) and write-from-`wdata[0]` (`bitOp`=3) change only the selected bit of the byte and produce no `rdValid`.
- R8: A push (mode 4) first increments the stack pointer, then writes `wdata` at the new pointer. A pop (mode 5) reads at the current pointer, then decrements it. Both use RAM only, the pointer wraps modulo 256, and it resets to 07h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqMode | input | 3 | Access mode: 0 direct, 1 indirect, 2 register, 3 bit, 4 push, 5 pop, 6 bank select |
| reqWrite | input | 1 | Write (1) or read (0) for modes 0–2 |
| bitOp | input | 2 | Bit operation: 0 read, 1 set, 2 clear, 3 write wdata[0] |
| addr | input | 8 | Byte address (modes 0, 1) or bit address (mode 3) |
| regNum | input | 3 | Register number within the bank (mode 2) |
| wdata | input | 8 | Write data, bit value or new bank |
| rdValid | output | 1 | Read data valid |
| rdata | output | 8 | Read data |
| stackPtr | output | 8 | Current stack pointer |
| bankSel | output | 2 | Current register bank |

## Verification
The assertions assume at most one request per cycle and a `reqMode` drawn from the seven defined codes. They assume that a bit access's byte comes only from `addr[6:0]`. They also assume that the stack pointer moves only when a push or pop is accepted. The stimulus drives each request for exactly one clock from the falling edge and never issues the unused mode code. It fills the whole RAM through the indirect path before it reads any byte, so no check depends on unreset contents.

// File: rtl/idm_pkg.sv
package idm_pkg;
  parameter int IDM_AW   = 8;
  parameter int IDM_DW   = 8;
  parameter int IDM_BANKS = 4;
  parameter int IDM_REGS = 8;
  parameter int IDM_BANK_W = $clog2(IDM_BANKS);
  parameter int IDM_REG_W  = $clog2(IDM_REGS);
  parameter int IDM_LANE_W = $clog2(IDM_DW);

  typedef enum logic [2:0] {
    MODE_DIRECT   = 3'd0,
    MODE_INDIRECT = 3'd1,
    MODE_REG      = 3'd2,
    MODE_BIT      = 3'd3,
    MODE_PUSH     = 3'd4,
    MODE_POP      = 3'd5,
    MODE_BANK     = 3'd6
  } accessMode_t;

  typedef enum logic [1:0] {
    BIT_READ = 2'd0,
    BIT_SET  = 2'd1,
    BIT_CLR  = 2'd2,
    BIT_PUT  = 2'd3
  } bitOp_t;

  typedef struct packed {
    logic                  ramWe;
    logic                  sfrWe;
    logic                  ramRd;
    logic                  sfrRd;
    logic                  bitRd;
    logic                  bitWr;
    logic [IDM_AW-1:0]     byteAddr;
    logic [IDM_LANE_W-1:0] bitPos;
    bitOp_t                bitOp;
  } dpStrobe_t;
endpackage

// File: rtl/idm_ctrl.sv
module idm_ctrl
  import idm_pkg::*;
#(
  parameter logic [IDM_AW-1:0] SP_RESET = 8'h07,
  parameter logic [IDM_AW-1:0] BIT_BASE = 8'h20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [2:0]            reqMode,
  input  logic                  reqWrite,
  input  logic [1:0]            bitOp,
  input  logic [IDM_AW-1:0]     addr,
  input  logic [IDM_REG_W-1:0]  regNum,
  input  logic [IDM_BANK_W-1:0] bankData,
  output dpStrobe_t             strb,
  output logic [IDM_AW-1:0]     stackPtr,
  output logic [IDM_BANK_W-1:0] bankSel
);
  localparam int BIT_HI = IDM_AW - 2;

  accessMode_t           mode;
  logic [IDM_AW-1:0]     spNext;
  logic [IDM_BANK_W-1:0] bankNext;
  logic [IDM_AW-1:0]     regAddr;
  logic [IDM_AW-1:0]     bitByte;
  logic                  upperHalf;

  assign mode      = accessMode_t'(reqMode);
  assign regAddr   = IDM_AW'({bankSel, regNum});
  assign bitByte   = BIT_BASE + IDM_AW'(addr[BIT_HI:IDM_LANE_W]);
  assign upperHalf = addr[IDM_AW-1];

  always_comb begin
    strb     = '0;
    spNext   = stackPtr;
    bankNext = bankSel;
    if (reqValid) begin
      case (mode)
        MODE_DIRECT: begin
          strb.byteAddr = addr;
          if (upperHalf) begin
            strb.sfrWe = reqWrite;
            strb.sfrRd = !reqWrite;
          end else begin
            strb.ramWe = reqWrite;
            strb.ramRd = !reqWrite;
          end
        end
        MODE_INDIRECT: begin
          strb.byteAddr = addr;
          strb.ramWe    = reqWrite;
          strb.ramRd    = !reqWrite;
        end
        MODE_REG: begin
          strb.byteAddr = regAddr;
          strb.ramWe    = reqWrite;
          strb.ramRd    = !reqWrite;
        end
        MODE_BIT: begin
          strb.byteAddr = bitByte;
          strb.bitPos   = addr[IDM_LANE_W-1:0];
          strb.bitOp    = bitOp_t'(bitOp);
          if (bitOp_t'(bitOp) == BIT_READ) strb.bitRd = 1'b1;
          else strb.bitWr = 1'b1;
        end
        MODE_PUSH: begin
          spNext        = stackPtr + IDM_AW'(1);
          strb.byteAddr = spNext;
          strb.ramWe    = 1'b1;
        end
        MODE_POP: begin
          strb.byteAddr = stackPtr;
          strb.ramRd    = 1'b1;
          spNext        = stackPtr - IDM_AW'(1);
        end
        MODE_BANK: bankNext = bankData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stackPtr <= SP_RESET;
      bankSel  <= '0;
    end else begin
      stackPtr <= spNext;
      bankSel  <= bankNext;
    end
  end

  assert_push_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_PUSH) |=> stackPtr == $past(stackPtr) + IDM_AW'(1));
  assert_pop_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode == MODE_POP) |=> stackPtr == $past(stackPtr) - IDM_AW'(1));
  assert_sp_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && (reqMode == MODE_PUSH || reqMode == MODE_POP)) |=> $stable(stackPtr));
  assert_bank_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(reqValid && reqMode == MODE_BANK) |=> $stable(bankSel));
endmodule

// File: rtl/idm_datapath.sv
module idm_datapath
  import idm_pkg::*;
#(
  parameter logic [IDM_DW-1:0] SFR_RESET = 8'h00
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [IDM_DW-1:0] wdata,
  output logic              rdValid,
  output logic [IDM_DW-1:0] rdata
);
  localparam int RAM_DEPTH = 1 << IDM_AW;
  localparam int SFR_DEPTH = RAM_DEPTH / 2;
  localparam int SFR_AW    = IDM_AW - 1;

  logic [IDM_DW-1:0] ramMem [RAM_DEPTH];
  logic [IDM_DW-1:0] sfrMem [SFR_DEPTH];
  logic [IDM_DW-1:0] curRam;
  logic [IDM_DW-1:0] curSfr;
  logic [IDM_DW-1:0] modByte;
  logic              curBit;
  logic              newBit;
  logic [SFR_AW-1:0] sfrIdx;

  assign sfrIdx = strb.byteAddr[SFR_AW-1:0];
  assign curRam = ramMem[strb.byteAddr];
  assign curSfr = sfrMem[sfrIdx];
  assign curBit = curRam[strb.bitPos];

  always_comb begin
    case (strb.bitOp)
      BIT_SET: newBit = 1'b1;
      BIT_CLR: newBit = 1'b0;
      BIT_PUT: newBit = wdata[0];
      default: newBit = curBit;
    endcase
  end

  for (genvar lane = 0; lane < IDM_DW; lane++) begin : gLane
    assign modByte[lane] = (strb.bitPos == IDM_LANE_W'(lane)) ? newBit : curRam[lane];
  end

  always_ff @(posedge clk) begin
    if (strb.ramWe) ramMem[strb.byteAddr] <= wdata;
    else if (strb.bitWr) ramMem[strb.byteAddr] <= modByte;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SFR_DEPTH; i++) sfrMem[i] <= SFR_RESET;
    end else if (strb.sfrWe) begin
      sfrMem[sfrIdx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdata   <= '0;
    end else begin
      rdValid <= strb.ramRd | strb.sfrRd | strb.bitRd;
      if (strb.ramRd) rdata <= curRam;
      else if (strb.sfrRd) rdata <= curSfr;
      else if (strb.bitRd) rdata <= IDM_DW'(curBit);
    end
  end

  assert_one_store_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.ramWe | strb.bitWr, strb.sfrWe}));
  assert_sfr_spares_ram_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.sfrWe |=> ramMem[$past(strb.byteAddr)] == $past(ramMem[strb.byteAddr]));
  assert_bit_only_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.bitWr |=> $onehot0(ramMem[$past(strb.byteAddr)] ^ $past(ramMem[strb.byteAddr])));
  assert_bit_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.bitWr || strb.ramWe || strb.sfrWe) |=> !rdValid);
endmodule

// File: rtl/idm_top.sv
module idm_top
  import idm_pkg::*;
#(
  parameter logic [IDM_AW-1:0] SP_RESET  = 8'h07,
  parameter logic [IDM_AW-1:0] BIT_BASE  = 8'h20,
  parameter logic [IDM_DW-1:0] SFR_RESET = 8'h00
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  reqValid,
  input  logic [2:0]            reqMode,
  input  logic                  reqWrite,
  input  logic [1:0]            bitOp,
  input  logic [IDM_AW-1:0]     addr,
  input  logic [IDM_REG_W-1:0]  regNum,
  input  logic [IDM_DW-1:0]     wdata,
  output logic                  rdValid,
  output logic [IDM_DW-1:0]     rdata,
  output logic [IDM_AW-1:0]     stackPtr,
  output logic [IDM_BANK_W-1:0] bankSel
);
  dpStrobe_t strb;

  idm_ctrl #(.SP_RESET(SP_RESET), .BIT_BASE(BIT_BASE)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqWrite(reqWrite), .bitOp(bitOp), .addr(addr), .regNum(regNum),
    .bankData(wdata[IDM_BANK_W-1:0]), .strb(strb), .stackPtr(stackPtr),
    .bankSel(bankSel)
  );

  idm_datapath #(.SFR_RESET(SFR_RESET)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(wdata),
    .rdValid(rdValid), .rdata(rdata)
  );
endmodule

// File: tb/tb_idm_top.sv
module tb_idm_top;
  localparam logic [2:0] M_DIR = 3'd0, M_IND = 3'd1, M_REG = 3'd2, M_BIT = 3'd3,
                         M_PUSH = 3'd4, M_POP = 3'd5, M_BANK = 3'd6;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqMode = '0;
  logic       reqWrite = 1'b0;
  logic [1:0] bitOp = '0;
  logic [7:0] addr = '0;
  logic [2:0] regNum = '0;
  logic [7:0] wdata = '0;
  logic       rdValid;
  logic [7:0] rdata;
  logic [7:0] stackPtr;
  logic [1:0] bankSel;

  int nChecks = 0;
  int nFail = 0;
  expItem_t expQ[$];
  logic [7:0] mRam [256];
  logic [7:0] mSfr [128];
  logic [7:0] mSp = 8'h07;
  logic [1:0] mBank = 2'd0;

  always #4 clk = ~clk;

  idm_top dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .reqWrite(reqWrite), .bitOp(bitOp), .addr(addr), .regNum(regNum),
    .wdata(wdata), .rdValid(rdValid), .rdata(rdata), .stackPtr(stackPtr),
    .bankSel(bankSel)
  );

  task automatic checkEq(input logic [7:0] got, input logic [7:0] exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  // Driver: drives one request at the falling edge and records the expected result
  task automatic doReq(input logic [2:0] m, input logic wr, input logic [1:0] bop,
                       input logic [7:0] a, input logic [2:0] r, input logic [7:0] d,
                       input string tag);
    logic [7:0] b;
    logic [2:0] p;
    expItem_t it;
    @(negedge clk);
    reqValid = 1'b1; reqMode = m; reqWrite = wr; bitOp = bop;
    addr = a; regNum = r; wdata = d;
    it.tag = tag;
    b = 8'h20 + {4'b0, a[6:3]};
    p = a[2:0];
    case (m)
      M_DIR: begin
        if (a[7]) begin
          if (wr) mSfr[a[6:0]] = d;
          else begin it.v = mSfr[a[6:0]]; expQ.push_back(it); end
        end else begin
          if (wr) mRam[a] = d;
          else begin it.v = mRam[a]; expQ.push_back(it); end
        end
      end
      M_IND: if (wr) mRam[a] = d; else begin it.v = mRam[a]; expQ.push_back(it); end
      M_REG: begin
        b = {3'b0, mBank, r};
        if (wr) mRam[b] = d; else begin it.v = mRam[b]; expQ.push_back(it); end
      end
      M_BIT: begin
        case (bop)
          2'd0: begin it.v = {7'b0, mRam[b][p]}; expQ.push_back(it); end
          2'd1: mRam[b][p] = 1'b1;
          2'd2: mRam[b][p] = 1'b0;
          default: mRam[b][p] = d[0];
        endcase
      end
      M_PUSH: begin mSp = mSp + 8'd1; mRam[mSp] = d; end
      M_POP: begin it.v = mRam[mSp]; expQ.push_back(it); mSp = mSp - 8'd1; end
      M_BANK: mBank = d[1:0];
      default: ;
    endcase
  endtask

  task automatic settle(input string tag);
    @(negedge clk);
    reqValid = 1'b0;
    checkEq(stackPtr, mSp, {tag, " stack pointer"});
    checkEq({6'b0, bankSel}, {6'b0, mBank}, {tag, " bank"});
  endtask

  // Monitor: each expected item must appear exactly one cycle after its request (R1)
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        checkEq({7'b0, rdValid}, 8'h01, {"R1 rdValid for ", it.tag});
        if (rdValid) checkEq(rdata, it.v, it.tag);
      end else if (rdValid) begin
        checkEq({7'b0, rdValid}, 8'h00, "R1 rdValid without read");
      end
    end
  end

  initial begin
    #(8 * 200000);
    nChecks++;
    nFail++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 128; i++) mSfr[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkEq(stackPtr, 8'h07, "R8 reset stack pointer");
    checkEq({6'b0, bankSel}, 8'h00, "R5 reset bank");
    checkEq({7'b0, rdValid}, 8'h00, "R1 reset rdValid");

    doReq(M_DIR, 0, 0, 8'h80, 0, 0, "R4 SFR reset 80h");
    doReq(M_DIR, 0, 0, 8'hFF, 0, 0, "R4 SFR reset FFh");
    doReq(M_DIR, 0, 0, 8'hC3, 0, 0, "R4 SFR reset C3h");
    settle("R4 after reset reads");

    for (int i = 0; i < 256; i++) doReq(M_IND, 1, 0, 8'(i), 0, 8'(i) ^ 8'h5A, "R3 fill");
    settle("fill");

    doReq(M_IND, 0, 0, 8'h00, 0, 0, "R2 indirect 00h");
    doReq(M_IND, 0, 0, 8'h7F, 0, 0, "R2 indirect 7Fh");
    doReq(M_IND, 0, 0, 8'h80, 0, 0, "R3 indirect 80h");
    doReq(M_IND, 0, 0, 8'hFF, 0, 0, "R3 indirect FFh");
    doReq(M_DIR, 0, 0, 8'h7F, 0, 0, "R2 direct 7Fh");
    doReq(M_DIR, 1, 0, 8'h30, 0, 8'h11, "R2 direct write 30h");
    doReq(M_IND, 0, 0, 8'h30, 0, 0, "R2 R1 indirect read after direct write");
    doReq(M_DIR, 0, 0, 8'h30, 0, 0, "R2 direct read 30h");
    settle("R2");

    doReq(M_DIR, 1, 0, 8'h90, 0, 8'hAA, "R4 SFR write 90h");
    doReq(M_IND, 0, 0, 8'h90, 0, 0, "R4 upper RAM 90h untouched");
    doReq(M_DIR, 0, 0, 8'h90, 0, 0, "R4 SFR 90h readback");
    doReq(M_IND, 1, 0, 8'hA0, 0, 8'h33, "R3 upper RAM write A0h");
    doReq(M_DIR, 0, 0, 8'hA0, 0, 0, "R4 SFR A0h untouched");
    doReq(M_IND, 0, 0, 8'hA0, 0, 0, "R3 upper RAM A0h readback");
    settle("R3 R4");

    for (int b = 0; b < 4; b++) begin
      doReq(M_BANK, 0, 0, 0, 0, 8'(b), "R5 bank select");
      settle("R5 bank select");
      doReq(M_REG, 1, 0, 0, 3'd5, 8'h40 + 8'(b), "R5 reg write");
      doReq(M_REG, 0, 0, 0, 3'd5, 0, "R5 reg read");
      doReq(M_IND, 0, 0, 8'(b * 8 + 5), 0, 0, "R5 reg alias via indirect");
      doReq(M_REG, 0, 0, 0, 3'd0, 0, "R5 reg 0 read");
      settle("R5 regs");
    end
    doReq(M_BANK, 1, 0, 0, 0, 8'hFD, "R5 bank from wdata low bits");
    doReq(M_REG, 0, 0, 0, 3'd7, 0, "R5 bank 1 reg 7");
    settle("R5 bank 1");

    doReq(M_IND, 1, 0, 8'h21, 0, 8'h00, "R6 clear byte 21h");
    doReq(M_BIT, 0, 2'd1, 8'h0B, 0, 0, "R7 set bit 0Bh");
    doReq(M_IND, 0, 0, 8'h21, 0, 0, "R7 byte 21h after set");
    doReq(M_BIT, 0, 2'd0, 8'h0B, 0, 0, "R6 bit read 0Bh");
    doReq(M_BIT, 0, 2'd0, 8'h0C, 0, 0, "R6 bit read 0Ch");
    doReq(M_BIT, 0, 2'd2, 8'h00, 0, 0, "R7 clear bit 00h");
    doReq(M_IND, 0, 0, 8'h20, 0, 0, "R7 byte 20h after clear");
    doReq(M_BIT, 0, 2'd3, 8'h7F, 0, 8'h00, "R7 write 0 bit 7Fh");
    doReq(M_IND, 0, 0, 8'h2F, 0, 0, "R7 byte 2Fh after write 0");
    doReq(M_BIT, 0, 2'd3, 8'h7F, 0, 8'hFF, "R7 write 1 bit 7Fh");
    doReq(M_BIT, 0, 2'd0, 8'h7F, 0, 0, "R6 bit read 7Fh");
    doReq(M_BIT, 0, 2'd1, 8'h8E, 0, 0, "R6 set with addr bit 7 high");
    doReq(M_IND, 0, 0, 8'h21, 0, 0, "R6 addr bit 7 ignored");
    doReq(M_DIR, 0, 0, 8'h81, 0, 0, "R6 SFR untouched by bit op");
    settle("R6 R7");

    doReq(M_PUSH, 0, 0, 0, 0, 8'hC1, "R8 push 1");
    settle("R8 push 1");
    doReq(M_PUSH, 0, 0, 0, 0, 8'hC2, "R8 push 2");
    doReq(M_IND, 0, 0, 8'h09, 0, 0, "R8 push landed at 09h");
    doReq(M_POP, 0, 0, 0, 0, 0, "R8 pop 2");
    doReq(M_POP, 0, 0, 0, 0, 0, "R8 pop 1");
    settle("R8 balanced");
    for (int i = 0; i < 8; i++) doReq(M_POP, 0, 0, 0, 0, 0, "R8 pop toward wrap");
    settle("R8 pop wrap to FFh");
    doReq(M_PUSH, 0, 0, 0, 0, 8'hE7, "R8 push wrap to 00h");
    settle("R8 push wrap");
    doReq(M_IND, 0, 0, 8'h00, 0, 0, "R8 push wrap data at 00h");
    doReq(M_DIR, 0, 0, 8'h80, 0, 0, "R8 stack never in SFR");
    doReq(M_POP, 0, 0, 0, 0, 0, "R8 pop at 00h");
    settle("R8 pop from 00h");

    doReq(M_IND, 1, 0, 8'h50, 0, 8'h9C, "R1 write 50h");
    doReq(M_IND, 0, 0, 8'h50, 0, 0, "R1 back-to-back read 50h");
    doReq(M_DIR, 1, 0, 8'hB0, 0, 8'h6E, "R1 write SFR B0h");
    doReq(M_DIR, 0, 0, 8'hB0, 0, 0, "R1 back-to-back SFR read");
    settle("R1");
    repeat (3) @(negedge clk);
    checkEq(8'(expQ.size()), 8'h00, "R1 no pending reads");
    finishRun();
  end
endmodule